// File: doc/BRIEF.md
# Cascaded Level Interrupt Aggregator

This block collects a set of level-sensitive interrupt request lines from peripheral devices and folds them into a single level output. That output drives one input of a parent CPU interrupt controller. Each source has an enable bit. A source counts as pending while its input is high and its enable bit is set. The block raises its output whenever at least one source is pending.

Software runs the block over a simple 32-bit register bus with word-aligned byte addresses. A handler reads the pending word to learn which sources need service. The mask is never written as a whole. Instead there are three write-only command registers:

- one sets the enable bits that are 1 in the written data;
- one clears the enable bits that are 1 in the written data;
- one clears every enable bit, whatever value is written.

Because of this, concurrent owners of different sources can change their own bits without a read-modify-write.

Top module: `lvl_irq_combiner`

## Requirements
- R1: After reset all enable bits are 0, `parentIrq` is 0 and `busRdData` is 0, so a pending read with every input high returns 0.
- R2: A read (`busRdEn`=1) at byte address 0x04 returns, on `busRdData` in the following cycle, the bitwise AND of `srcLevel` and the enable mask, with bit i corresponding to source i (0 to 31).
- R3: A write at 0x10 sets every enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R4: A write at 0x0C clears every enable bit whose data bit is 1 and leaves every other enable bit unchanged.
- R5: A write of any value at 0x08 clears all enable bits. Two cycles after that write, `parentIrq` is 0.
- R6: `parentIrq` is a register holding the OR of all pending bits. It changes one clock edge after a change in input level and two edges after the mask write that causes the change.
- R7: Sources are level-sensitive. A pending bit follows its input while the source is enabled and drops as soon as the input drops, with nothing latched.
- R8: Reads at any address other than 0x04 return 0. Writes at addresses other than 0x08, 0x0C and 0x10 leave the mask unchanged.
- R9: In a cycle after one with `busRdEn`=0, `busRdData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data, valid the cycle after `busRdEn` |
| srcLevel | input | 32 | Raw interrupt request levels, bit i is source i |
| parentIrq | output | 1 | Combined level request to the parent controller |

## Verification
The hardest state to reach from the ports is the mask itself. It cannot be read back. It shows only through the pending word and the output line, and only for sources whose inputs are high.

The stimulus therefore holds all 32 inputs high while it issues enable, disable, disable-all and stray-address writes. It then reads the pending word, which at that moment equals the mask. This exposes bits that were touched by mistake and bits that were wrongly left alone.

The two-edge latency from a mask write to the output is checked cycle by cycle: the output is checked still low one cycle after the enable write and high on the next.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Register byte offsets; software depends on these values.
  localparam int OFF_PENDING = 'h04;
  localparam int OFF_MASKALL = 'h08;
  localparam int OFF_MASKSEL = 'h0C;
  localparam int OFF_UNMASK  = 'h10;

  // Control-to-datapath strobes, at most one write strobe per cycle.
  typedef struct packed {
    logic clrAll;
    logic clrSel;
    logic setSel;
    logic rdPend;
  } strobe_t;
endpackage

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           strobes
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PENDING);
  localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(OFF_MASKALL);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(OFF_MASKSEL);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFF_UNMASK);

  always_comb begin
    strobes        = '0;
    strobes.rdPend = busRdEn && (busAddr == A_PEND);
    if (busWrEn) begin
      unique case (busAddr)
        A_ALL:   strobes.clrAll = 1'b1;
        A_SEL:   strobes.clrSel = 1'b1;
        A_SET:   strobes.setSel = 1'b1;
        default: strobes        = strobes;
      endcase
    end
  end
endmodule

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] pending;

  // Per-source enable bit; clearing wins over setting.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN)                                 enMask[i] <= 1'b0;
      else if (strobes.clrAll)                   enMask[i] <= 1'b0;
      else if (strobes.clrSel && wrData[i])      enMask[i] <= 1'b0;
      else if (strobes.setSel && wrData[i])      enMask[i] <= 1'b1;
    end
    assign pending[i] = srcLevel[i] & enMask[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      rdData <= '0;
    end else begin
      irqOut <= |pending;
      rdData <= strobes.rdPend ? DATA_W'(pending) : '0;
    end
  end
endmodule

// File: rtl/lvl_irq_combiner.sv
module lvl_irq_combiner
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busRdEn,
  output logic [DATA_W-1:0]  busRdData,
  input  logic [NUM_SRC-1:0] srcLevel,
  output logic               parentIrq
);
  strobe_t strobes;

  lvl_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  lvl_irq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (busWrData),
    .srcLevel (srcLevel),
    .rdData   (busRdData),
    .irqOut   (parentIrq)
  );
endmodule

// File: rtl/lvl_irq_checker.sv
module lvl_irq_checker #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [DATA_W-1:0]  busRdData,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic               parentIrq
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ALL  = ADDR_W'(8);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!parentIrq && busRdData == '0));                             // R1
  AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == A_PEND) |=> ((busRdData & ~DATA_W'($past(srcLevel))) == '0)); // R2
  AST_MASKALL_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_ALL) |=> ##1 !parentIrq);                            // R5
  AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (parentIrq && !$rose(rstN)) |-> ($past(srcLevel) != '0));                     // R6
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr != A_PEND) |=> (busRdData == '0));                        // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn) |=> (busRdData == '0));                                            // R9
endmodule

bind lvl_irq_combiner lvl_irq_checker #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busRdData (busRdData),
  .srcLevel  (srcLevel),
  .parentIrq (parentIrq)
);

// File: tb/tb_lvl_irq_combiner.sv
`timescale 1ns/1ps
module tb_lvl_irq_combiner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic [31:0] srcLevel = '0;
  logic        parentIrq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lvl_irq_combiner dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .srcLevel(srcLevel), .parentIrq(parentIrq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq after reset", {31'b0, parentIrq}, 32'h0);
    check("R1 rdData after reset", busRdData, 32'h0);
    srcLevel = '1;
    busRead(8'h04, v);
    check("R1 mask clear after reset", v, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    srcLevel = '1;
    busWrite(8'h10, 32'h0000_00F0);
    check("R6 irq one edge after mask write", {31'b0, parentIrq}, 32'h0);
    @(negedge clk);
    check("R6 irq two edges after mask write", {31'b0, parentIrq}, 32'h1);
    busRead(8'h04, v);
    check("R3 enable selected bits", v, 32'h0000_00F0);
    busWrite(8'h10, 32'h8000_0001);
    busRead(8'h04, v);
    check("R3 enable keeps others", v, 32'h8000_00F1);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    busWrite(8'h0C, 32'h8000_0030);
    busRead(8'h04, v);
    check("R4 disable selected bits", v, 32'h0000_00C1);
  endtask

  task automatic t_level;
    logic [31:0] v;
    srcLevel = 32'h0000_0080;
    busRead(8'h04, v);
    check("R2 pending is level and mask", v, 32'h0000_0080);
    check("R6 irq with one pending", {31'b0, parentIrq}, 32'h1);
    srcLevel = 32'h0000_0100;  // not enabled
    @(negedge clk);
    check("R7 pending drops with input", {31'b0, parentIrq}, 32'h0);
    busRead(8'h04, v);
    check("R7 pending word after drop", v, 32'h0);
    srcLevel = 32'h0000_0001;
    @(negedge clk);
    check("R6 irq one edge after level rise", {31'b0, parentIrq}, 32'h1);
  endtask

  task automatic t_clear_all;
    logic [31:0] v;
    srcLevel = '1;
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h08, 32'h0);
    busRead(8'h04, v);
    check("R5 disable-all with zero data", v, 32'h0);
    check("R5 irq low after disable-all", {31'b0, parentIrq}, 32'h0);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    srcLevel = '1;
    busWrite(8'h10, 32'h0000_0005);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h0D, 32'hFFFF_FFFF);
    busRead(8'h04, v);
    check("R8 stray writes ignored", v, 32'h0000_0005);
    busRead(8'h00, v);
    check("R8 read of offset 0x00", v, 32'h0);
    busRead(8'h10, v);
    check("R8 read of write-only 0x10", v, 32'h0);
  endtask

  task automatic t_idle;
    busAddr = 8'h04;
    @(negedge clk);
    check("R9 no read gives zero", busRdData, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_disable();
    t_level();
    t_clear_all();
    t_undef();
    t_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule